// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits at the execute stage of a five-stage in-order pipeline. It takes the two source register indices of the instruction in execute and compares each one against the destination index of the instruction one stage ahead (memory) and two stages ahead (write-back). From those comparisons it forms a 2-bit source code per operand. It then uses that code to pick the ALU operand: the register-file value carried down from decode, the memory-stage ALU result, or the write-back value.

The logic is purely combinational. The select codes and operands settle in the same cycle that the indices and values are presented, with no clock and no reset. There is no stream interface: every pin is plain control or data that is sampled by neighbouring pipeline registers. Pipeline freezing on a load-use hazard is handled elsewhere, and so is branch resolution.

The source code encoding is: 2'b00 selects the register-file value, 2'b01 the write-back value, 2'b10 the memory-stage result, and 2'b11 is never produced and also maps to the register-file value.

Top module: `exu_bypass_sel`

## Requirements
- R1: When the memory stage has its write enable set, its destination index is nonzero and equal to an operand's source index, that operand's code is 2'b10 and the operand equals the memory-stage result.
- R2: When the write-back stage has its write enable set, its destination index is nonzero and equal to an operand's source index, and the memory stage does not also qualify for that operand, the code is 2'b01 and the operand equals the write-back value.
- R3: When both later stages qualify for the same operand, the memory stage (the newer result) wins: the code is 2'b10 and the operand is the memory-stage result.
- R4: A destination index of zero is never bypassed from either stage, even with its write enable set; such a stage counts as not matching.
- R5: A stage whose write enable is clear is never bypassed, even when its destination index equals the source index.
- R6: When no stage qualifies for an operand, its code is 2'b00 and the operand equals the register-file value supplied for it.
- R7: Operands A and B are resolved independently. In one cycle they may take different codes, or both take the same later stage.
- R8: The codes and operands are combinational functions of the current inputs and follow an input change without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | 5 | Source register index for operand A of the execute-stage instruction |
| ex_src_b_idx | input | 5 | Source register index for operand B |
| ex_rf_a | input | DATA_W | Register-file value for operand A carried from decode |
| ex_rf_b | input | DATA_W | Register-file value for operand B carried from decode |
| mem_wr_en | input | 1 | Memory-stage instruction will write a register |
| mem_dst_idx | input | 5 | Memory-stage destination register index |
| mem_result | input | DATA_W | Memory-stage ALU result |
| wb_wr_en | input | 1 | Write-back-stage instruction will write a register |
| wb_dst_idx | input | 5 | Write-back-stage destination register index |
| wb_result | input | DATA_W | Value being written back |
| opnd_a | output | DATA_W | Selected ALU operand A |
| opnd_b | output | DATA_W | Selected ALU operand B |
| sel_a | output | 2 | Source code for operand A |
| sel_b | output | 2 | Source code for operand B |

## Verification
The bench goes after the case where both later stages write the same register that execute reads. A selector with the priority inverted would hand the ALU a stale value from two instructions back. It drives register zero as a destination with write enable set; a design that omits the nonzero test would bypass a value that the register file discards. It presents matching indices with write enable clear, which catches a design that keys on the index alone. Random traffic over a narrow index range makes both operands hit at once, so it exposes any cross-coupling between A and B.

// File: rtl/exu_bypass_pkg.sv
package exu_bypass_pkg;

  // Operand source code; 2'b11 is reserved and never produced.
  typedef enum logic [1:0] {
    SRC_RF   = 2'b00,
    SRC_WB   = 2'b01,
    SRC_MEM  = 2'b10,
    SRC_RSVD = 2'b11
  } byp_src_e;

endpackage

// File: rtl/exu_byp_hit.sv
// Qualifies one later stage against one source index.
module exu_byp_hit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_idx,
  input  logic             wr_en,
  input  logic [REG_W-1:0] dst_idx,
  output logic             hit
);
  logic dst_nonzero;
  assign dst_nonzero = |dst_idx;
  assign hit = wr_en && dst_nonzero && (dst_idx == src_idx);
endmodule

// File: rtl/exu_byp_pick.sv
// Priority: the memory stage holds the newer result, so it wins.
module exu_byp_pick
  import exu_bypass_pkg::*;
(
  input  logic     mem_hit,
  input  logic     wb_hit,
  output byp_src_e sel
);
  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/exu_byp_mux.sv
module exu_byp_mux
  import exu_bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  byp_src_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SRC_MEM: opnd = mem_val;
      SRC_WB:  opnd = wb_val;
      default: opnd = rf_val;   // SRC_RF and the reserved code
    endcase
  end
endmodule

// File: rtl/exu_bypass_sel.sv
module exu_bypass_sel
  import exu_bypass_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [REG_W-1:0]  ex_src_a_idx,
  input  logic [REG_W-1:0]  ex_src_b_idx,
  input  logic [DATA_W-1:0] ex_rf_a,
  input  logic [DATA_W-1:0] ex_rf_b,
  input  logic              mem_wr_en,
  input  logic [REG_W-1:0]  mem_dst_idx,
  input  logic [DATA_W-1:0] mem_result,
  input  logic              wb_wr_en,
  input  logic [REG_W-1:0]  wb_dst_idx,
  input  logic [DATA_W-1:0] wb_result,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);
  localparam int NUM_SRC = 2;

  logic [REG_W-1:0]  src_idx [NUM_SRC];
  logic [DATA_W-1:0] rf_val  [NUM_SRC];
  logic [DATA_W-1:0] opnd    [NUM_SRC];
  byp_src_e          sel     [NUM_SRC];

  assign src_idx[0] = ex_src_a_idx;
  assign src_idx[1] = ex_src_b_idx;
  assign rf_val[0]  = ex_rf_a;
  assign rf_val[1]  = ex_rf_b;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic mem_hit;
    logic wb_hit;

    exu_byp_hit #(.REG_W(REG_W)) u_mem_hit (
      .src_idx (src_idx[g]),
      .wr_en   (mem_wr_en),
      .dst_idx (mem_dst_idx),
      .hit     (mem_hit)
    );

    exu_byp_hit #(.REG_W(REG_W)) u_wb_hit (
      .src_idx (src_idx[g]),
      .wr_en   (wb_wr_en),
      .dst_idx (wb_dst_idx),
      .hit     (wb_hit)
    );

    exu_byp_pick u_pick (
      .mem_hit (mem_hit),
      .wb_hit  (wb_hit),
      .sel     (sel[g])
    );

    exu_byp_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel[g]),
      .rf_val  (rf_val[g]),
      .mem_val (mem_result),
      .wb_val  (wb_result),
      .opnd    (opnd[g])
    );
  end

  assign opnd_a = opnd[0];
  assign opnd_b = opnd[1];
  assign sel_a  = sel[0];
  assign sel_b  = sel[1];
endmodule

// File: rtl/exu_bypass_sel_chk.sv
module exu_bypass_sel_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [REG_W-1:0]  ex_src_a_idx,
  input logic [REG_W-1:0]  ex_src_b_idx,
  input logic [DATA_W-1:0] ex_rf_a,
  input logic [DATA_W-1:0] ex_rf_b,
  input logic              mem_wr_en,
  input logic [REG_W-1:0]  mem_dst_idx,
  input logic [DATA_W-1:0] mem_result,
  input logic              wb_wr_en,
  input logic [REG_W-1:0]  wb_dst_idx,
  input logic [DATA_W-1:0] wb_result,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b
);
  always_comb begin
    // R1: a memory-stage code delivers the memory-stage result
    a_r1_mem_data_a: assert (sel_a != 2'b10 || opnd_a == mem_result);
    a_r1_mem_data_b: assert (sel_b != 2'b10 || opnd_b == mem_result);
    // R2: a write-back code delivers the write-back value
    a_r2_wb_data_a: assert (sel_a != 2'b01 || opnd_a == wb_result);
    a_r2_wb_data_b: assert (sel_b != 2'b01 || opnd_b == wb_result);
    // R3: write-back is never chosen while the memory stage writes that index
    a_r3_mem_first_a: assert (sel_a != 2'b01 ||
      !(mem_wr_en && mem_dst_idx == ex_src_a_idx && mem_dst_idx != '0));
    // R4: nothing bypassed ever names register zero
    a_r4_no_zero_a: assert (sel_a == 2'b00 || ex_src_a_idx != '0);
    a_r4_no_zero_b: assert (sel_b == 2'b00 || ex_src_b_idx != '0);
    // R5: a bypass from a stage needs that stage's write enable
    a_r5_need_we_a: assert ((sel_a != 2'b10 || mem_wr_en) && (sel_a != 2'b01 || wb_wr_en));
    a_r5_need_we_b: assert ((sel_b != 2'b10 || mem_wr_en) && (sel_b != 2'b01 || wb_wr_en));
    // R6: default code carries the register-file value; reserved code is never produced
    a_r6_rf_data_a: assert (sel_a != 2'b00 || opnd_a == ex_rf_a);
    a_r6_rf_data_b: assert (sel_b != 2'b00 || opnd_b == ex_rf_b);
    a_r6_no_rsvd: assert (sel_a != 2'b11 && sel_b != 2'b11);
    // R7: identical source indices resolve to identical codes
    a_r7_same_idx: assert (ex_src_a_idx != ex_src_b_idx || sel_a == sel_b);
  end
endmodule

bind exu_bypass_sel exu_bypass_sel_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .ex_src_a_idx (ex_src_a_idx),
  .ex_src_b_idx (ex_src_b_idx),
  .ex_rf_a      (ex_rf_a),
  .ex_rf_b      (ex_rf_b),
  .mem_wr_en    (mem_wr_en),
  .mem_dst_idx  (mem_dst_idx),
  .mem_result   (mem_result),
  .wb_wr_en     (wb_wr_en),
  .wb_dst_idx   (wb_dst_idx),
  .wb_result    (wb_result),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .sel_a        (sel_a),
  .sel_b        (sel_b)
);

// File: tb/exu_bypass_sel_tb.sv
`timescale 1ns/1ps
module exu_bypass_sel_tb;
  localparam int DATA_W = 32;
  localparam int REG_W  = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [REG_W-1:0]  src_a = '0, src_b = '0, mem_dst = '0, wb_dst = '0;
  logic [DATA_W-1:0] rf_a = '0, rf_b = '0, mem_res = '0, wb_res = '0;
  logic              mem_we = 1'b0, wb_we = 1'b0;
  logic [DATA_W-1:0] opnd_a, opnd_b;
  logic [1:0]        sel_a, sel_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  exu_bypass_sel #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dut (
    .ex_src_a_idx (src_a), .ex_src_b_idx (src_b),
    .ex_rf_a (rf_a), .ex_rf_b (rf_b),
    .mem_wr_en (mem_we), .mem_dst_idx (mem_dst), .mem_result (mem_res),
    .wb_wr_en (wb_we), .wb_dst_idx (wb_dst), .wb_result (wb_res),
    .opnd_a (opnd_a), .opnd_b (opnd_b), .sel_a (sel_a), .sel_b (sel_b)
  );

  function automatic logic [1:0] exp_sel(logic [REG_W-1:0] s);
    if (mem_we && mem_dst != 0 && mem_dst == s) return 2'b10;
    if (wb_we && wb_dst != 0 && wb_dst == s)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] exp_opnd(logic [REG_W-1:0] s, logic [DATA_W-1:0] rf);
    case (exp_sel(s))
      2'b10:   return mem_res;
      2'b01:   return wb_res;
      default: return rf;
    endcase
  endfunction

  function automatic string tag_for(logic [REG_W-1:0] s);
    logic [1:0] e = exp_sel(s);
    if (e == 2'b10 && wb_we && wb_dst == s) return "R3";
    if (e == 2'b10) return "R1";
    if (e == 2'b01) return "R2";
    if ((mem_we && mem_dst == s) || (wb_we && wb_dst == s)) return "R4";
    if (mem_dst == s || wb_dst == s) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string force_tag);
    string ta = (force_tag != "") ? force_tag : tag_for(src_a);
    string tb = (force_tag != "") ? force_tag : tag_for(src_b);
    check(ta, "sel_a",  {30'd0, sel_a}, {30'd0, exp_sel(src_a)});
    check(ta, "opnd_a", opnd_a, exp_opnd(src_a, rf_a));
    check(tb, "sel_b",  {30'd0, sel_b}, {30'd0, exp_sel(src_b)});
    check(tb, "opnd_b", opnd_b, exp_opnd(src_b, rf_b));
  endtask

  task automatic drive(logic [REG_W-1:0] sa, logic [REG_W-1:0] sb,
                       logic mwe, logic [REG_W-1:0] md,
                       logic wwe, logic [REG_W-1:0] wd);
    @(negedge clk);
    src_a = sa; src_b = sb; mem_we = mwe; mem_dst = md; wb_we = wwe; wb_dst = wd;
    rf_a = $urandom; rf_b = $urandom; mem_res = $urandom; wb_res = $urandom;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R6: idle state, nothing writing
    drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
    check_all("R6");
    // R1: memory stage match on A only, then B only
    drive(5'd3, 5'd7, 1'b1, 5'd3, 1'b0, 5'd0);  check_all("R1");
    drive(5'd3, 5'd7, 1'b1, 5'd7, 1'b0, 5'd0);  check_all("R1");
    // R2: write-back match on A, then B
    drive(5'd9, 5'd4, 1'b0, 5'd9, 1'b1, 5'd9);  check_all("R2");
    drive(5'd9, 5'd4, 1'b1, 5'd1, 1'b1, 5'd4);  check_all("R2");
    // R3: both stages target the same source
    drive(5'd12, 5'd12, 1'b1, 5'd12, 1'b1, 5'd12); check_all("R3");
    // R4: register zero with write enable in both stages
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);  check_all("R4");
    // R4: zero in memory stage must not mask a write-back hit elsewhere
    drive(5'd0, 5'd6, 1'b1, 5'd0, 1'b1, 5'd6);  check_all("R4");
    // R5: matching indices with write enables clear
    drive(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8);  check_all("R5");
    // R7: A from memory, B from write-back in the same cycle
    drive(5'd2, 5'd5, 1'b1, 5'd2, 1'b1, 5'd5);  check_all("R7");
    // R7: both operands from the memory stage
    drive(5'd11, 5'd11, 1'b1, 5'd11, 1'b0, 5'd0); check_all("R7");
    // R8: change a value without a clock edge; operand follows at once
    drive(5'd2, 5'd5, 1'b1, 5'd2, 1'b1, 5'd5);
    #0.5 mem_res = 32'hCAFE_F00D; #0.2;
    check("R8", "opnd_a", opnd_a, 32'hCAFE_F00D);
    mem_we = 1'b0; #0.2;
    check("R8", "sel_a", {30'd0, sel_a}, 32'd0);
    check("R8", "opnd_a", opnd_a, rf_a);

    // Random traffic over a narrow index range to make hits frequent
    for (int i = 0; i < 3000; i++) begin
      drive(REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
            1'($urandom), REG_W'($urandom_range(0, 3)),
            1'($urandom), REG_W'($urandom_range(0, 3)));
      check_all("");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule